// File: doc/BRIEF.md
# Broadcast Response Cross-Checker for Identical Routers

This block serves a test wrapper that exercises a group of identical routers at the same time. A single stimulus word is copied unchanged to the matching scan-chain and data inputs of every router. Each router's scan-out and data-out bits come back on its own response slice. The block then checks these slices against each other on every qualified cycle. It needs no stored golden response, because identical routers given identical stimulus must answer identically.

There are two modes. In the cross-check mode, any router whose response differs from router 0 raises a sticky fail flag. In the locate mode, a per-bit majority vote is taken across all routers. Each router that disagrees with the majority on any bit is marked in a failing-router mask. The fail flag, the mask and the index of the first failing compare cycle are held until a clear is given. Scan-load cycles, whose outputs are meaningless, are skipped by holding the compare-valid strobe low.

Top module: `bcast_resp_checker`

## Requirements
- R1: Every NUM_RTR slice of `rtr_stim` (slice i at bits i*STIM_W upward) equals `stim_in` in the same cycle, with no register on the path.
- R2: While `rst` is high and on the first cycle after it, `fail` is 0, `fail_mask` is all zeros and `first_fail_idx` is 0.
- R3: On a clock edge where `cmp_valid` is 1 and the router response slices are not all equal (slice i at bits i*RSP_W upward), `fail` reads 1 after that edge, in either mode (`diag_mode` 0 = cross-check, 1 = locate).
- R4: On an edge where `cmp_valid` is 0 and `clear` is 0, none of `fail`, `fail_mask` or `first_fail_idx` changes, whatever the response slices hold.
- R5: In cross-check mode (`diag_mode` = 0), `fail_mask` does not change on any edge without `clear`.
- R6: In locate mode with `cmp_valid` = 1, the majority value of each response bit is 1 when more than half of the routers drive 1 on it. Bit i of `fail_mask` is set after the edge if router i differs from the majority on any bit. Set bits are kept (ORed) across cycles.
- R7: `first_fail_idx` holds the number of `cmp_valid` cycles seen since reset or clear before the first failing one. It does not change while `fail` stays 1. The counter stops at its maximum value.
- R8: `clear` high on an edge zeroes `fail`, `fail_mask`, `first_fail_idx` and the valid-cycle count. It takes priority over a compare on the same edge.
- R9: Once set, `fail` stays 1 through later passing or idle cycles until `clear` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stim_in | input | STIM_W | Stimulus word to broadcast |
| rtr_stim | output | NUM_RTR*STIM_W | Stimulus copy for each router |
| rsp_in | input | NUM_RTR*RSP_W | Response slice of each router |
| cmp_valid | input | 1 | Qualifies the current cycle for comparison |
| diag_mode | input | 1 | 0 = cross-check, 1 = locate failing router |
| clear | input | 1 | Clears the latched results and count |
| fail | output | 1 | Sticky mismatch flag |
| fail_mask | output | NUM_RTR | Routers found to disagree with the majority |
| first_fail_idx | output | CNT_W | Valid-cycle index of the first mismatch |

## Verification
The bench first applies identical responses on valid cycles, which must leave every result at zero. It then applies one flipped bit in a single router, which shows the cross-check reacts to the smallest possible disagreement. Mismatches driven with the strobe low show that unqualified cycles are ignored. In locate mode, flips in several routers on different bits, and a two-router minority on one shared bit, check that the vote blames the minority and that the mask accumulates. A clear given on the same edge as a failing compare shows that clear wins, and a randomized tail mixes modes, strobes and clears against the bench's own model.

// File: rtl/bcast_cmp_pkg.sv
package bcast_cmp_pkg;

    typedef enum logic {
        MODE_XCHK = 1'b0,
        MODE_LOCATE = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic      clr;
        logic      valid;
        cmp_mode_e mode;
    } log_ctl_t;

    // True when strictly more than half of n voters drive a one
    function automatic logic majority_of(input int ones, input int n);
        return (2 * ones) > n;
    endfunction

endpackage

// File: rtl/bcast_xor_cmp.sv
module bcast_xor_cmp #(
    parameter int NUM_RTR = 5,
    parameter int RSP_W   = 8
) (
    input  logic [NUM_RTR*RSP_W-1:0] rsp,
    output logic [RSP_W-1:0]         diff_bits,
    output logic                     any_diff
);
    logic [RSP_W-1:0] ref_rsp;
    assign ref_rsp = rsp[RSP_W-1:0];

    always_comb begin
        diff_bits = '0;
        for (int i = 1; i < NUM_RTR; i++) begin
            diff_bits = diff_bits | (rsp[i*RSP_W +: RSP_W] ^ ref_rsp);
        end
    end

    assign any_diff = |diff_bits;
endmodule

// File: rtl/bcast_vote.sv
module bcast_vote
    import bcast_cmp_pkg::*;
#(
    parameter int NUM_RTR = 5,
    parameter int RSP_W   = 8
) (
    input  logic [NUM_RTR*RSP_W-1:0] rsp,
    output logic [RSP_W-1:0]         maj_bits,
    output logic [NUM_RTR-1:0]       dis_mask
);
    always_comb begin
        for (int b = 0; b < RSP_W; b++) begin
            int ones;
            ones = 0;
            for (int i = 0; i < NUM_RTR; i++) begin
                ones = ones + int'(rsp[i*RSP_W + b]);
            end
            maj_bits[b] = majority_of(ones, NUM_RTR);
        end
    end

    for (genvar i = 0; i < NUM_RTR; i++) begin : g_dis
        assign dis_mask[i] = |(rsp[i*RSP_W +: RSP_W] ^ maj_bits);
    end
endmodule

// File: rtl/bcast_fail_log.sv
module bcast_fail_log
    import bcast_cmp_pkg::*;
#(
    parameter int NUM_RTR = 5,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  log_ctl_t           ctl,
    input  logic               hit,
    input  logic [NUM_RTR-1:0] dis_mask,
    output logic               fail,
    output logic [NUM_RTR-1:0] fail_mask,
    output logic [CNT_W-1:0]   first_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            fail      <= 1'b0;
            fail_mask <= '0;
            first_idx <= '0;
            vcnt      <= '0;
        end else if (ctl.valid) begin
            if (ctl.mode == MODE_LOCATE) begin
                fail_mask <= fail_mask | dis_mask;
            end
            if (hit && !fail) begin
                fail      <= 1'b1;
                first_idx <= vcnt;
            end
            if (vcnt != CNT_MAX) begin
                vcnt <= vcnt + 1'b1;
            end
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst) (fail && !ctl.clr) |=> fail); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!ctl.valid && !ctl.clr) |=> ($stable(fail) && $stable(fail_mask) && $stable(first_idx))); // R4
    AST_MASK_XCHK_HOLD: assert property (@(posedge clk) disable iff (rst) (ctl.mode == MODE_XCHK && !ctl.clr) |=> $stable(fail_mask)); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) ctl.clr |=> (!fail && fail_mask == '0 && first_idx == '0)); // R8
    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst) (fail && !ctl.clr) |=> $stable(first_idx)); // R7
    AST_HIT_SETS_FAIL: assert property (@(posedge clk) disable iff (rst) (ctl.valid && hit && !ctl.clr) |=> fail); // R3
endmodule

// File: rtl/bcast_resp_checker.sv
module bcast_resp_checker
    import bcast_cmp_pkg::*;
#(
    parameter int NUM_RTR = 5,
    parameter int STIM_W  = 6,
    parameter int RSP_W   = 8,
    parameter int CNT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [STIM_W-1:0]         stim_in,
    output logic [NUM_RTR*STIM_W-1:0] rtr_stim,
    input  logic [NUM_RTR*RSP_W-1:0]  rsp_in,
    input  logic                      cmp_valid,
    input  logic                      diag_mode,
    input  logic                      clear,
    output logic                      fail,
    output logic [NUM_RTR-1:0]        fail_mask,
    output logic [CNT_W-1:0]          first_fail_idx
);
    for (genvar i = 0; i < NUM_RTR; i++) begin : g_bcast
        assign rtr_stim[i*STIM_W +: STIM_W] = stim_in;
    end

    logic [RSP_W-1:0]   diff_bits;
    logic               any_diff;
    logic [RSP_W-1:0]   maj_bits;
    logic [NUM_RTR-1:0] dis_mask;
    log_ctl_t           ctl;
    logic               hit;

    bcast_xor_cmp #(.NUM_RTR(NUM_RTR), .RSP_W(RSP_W)) u_xor (
        .rsp(rsp_in), .diff_bits(diff_bits), .any_diff(any_diff)
    );

    bcast_vote #(.NUM_RTR(NUM_RTR), .RSP_W(RSP_W)) u_vote (
        .rsp(rsp_in), .maj_bits(maj_bits), .dis_mask(dis_mask)
    );

    always_comb begin
        ctl.clr   = clear;
        ctl.valid = cmp_valid;
        ctl.mode  = cmp_mode_e'(diag_mode);
        hit       = (ctl.mode == MODE_LOCATE) ? (|dis_mask) : any_diff;
    end

    bcast_fail_log #(.NUM_RTR(NUM_RTR), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst(rst), .ctl(ctl), .hit(hit), .dis_mask(dis_mask),
        .fail(fail), .fail_mask(fail_mask), .first_idx(first_fail_idx)
    );

    AST_VOTE_AGREES_XOR: assert property (@(posedge clk) disable iff (rst) (|dis_mask) == any_diff); // R6
    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!fail && fail_mask == '0 && first_fail_idx == '0)); // R2
endmodule

// File: tb/tb_bcast_resp_checker.sv
module tb_bcast_resp_checker;
    localparam int N  = 5;
    localparam int SW = 6;
    localparam int W  = 8;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [SW-1:0]   stim_in;
    logic [N*SW-1:0] rtr_stim;
    logic [N*W-1:0]  rsp_in;
    logic            cmp_valid, diag_mode, clear;
    logic            fail;
    logic [N-1:0]    fail_mask;
    logic [CW-1:0]   first_fail_idx;

    bcast_resp_checker #(.NUM_RTR(N), .STIM_W(SW), .RSP_W(W), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .stim_in(stim_in), .rtr_stim(rtr_stim),
        .rsp_in(rsp_in), .cmp_valid(cmp_valid), .diag_mode(diag_mode),
        .clear(clear), .fail(fail), .fail_mask(fail_mask),
        .first_fail_idx(first_fail_idx)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          f;
        logic [N-1:0]  m;
        logic [CW-1:0] idx;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic          m_fail;
    logic [N-1:0]  m_mask;
    logic [CW-1:0] m_first;
    logic [CW-1:0] m_cnt;

    function automatic logic [N*W-1:0] mk(input logic [W-1:0] base, input logic [N*W-1:0] flips);
        return {N{base}} ^ flips;
    endfunction

    task automatic step(input logic [SW-1:0] s, input logic [N*W-1:0] r,
                        input logic v, input logic d, input logic c, input string tag);
        exp_t e;
        logic [W-1:0] maj;
        logic any;
        @(negedge clk);
        stim_in = s; rsp_in = r; cmp_valid = v; diag_mode = d; clear = c;
        #1;
        for (int i = 0; i < N; i++) begin
            checks++;
            if (rtr_stim[i*SW +: SW] !== s) begin
                errors++;
                $display("FAIL R1 broadcast slice %0d: actual %h expected %h", i, rtr_stim[i*SW +: SW], s);
            end
        end
        if (c) begin
            m_fail = 0; m_mask = '0; m_first = '0; m_cnt = '0;
        end else if (v) begin
            any = 0;
            for (int i = 1; i < N; i++) if (r[i*W +: W] != r[W-1:0]) any = 1;
            for (int b = 0; b < W; b++) begin
                int ones;
                ones = 0;
                for (int i = 0; i < N; i++) ones += int'(r[i*W + b]);
                maj[b] = (ones * 2 > N);
            end
            if (d) for (int i = 0; i < N; i++) if (r[i*W +: W] != maj) m_mask[i] = 1'b1;
            if (any && !m_fail) begin m_fail = 1; m_first = m_cnt; end
            if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
        end
        e.f = m_fail; e.m = m_mask; e.idx = m_first; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops one expected item per edge, 5 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (fail !== e.f || fail_mask !== e.m || first_fail_idx !== e.idx) begin
                    errors++;
                    $display("FAIL %s: actual fail=%b mask=%b idx=%0d expected fail=%b mask=%b idx=%0d",
                             e.tag, fail, fail_mask, first_fail_idx, e.f, e.m, e.idx);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] fl;
        rst = 1; stim_in = '0; rsp_in = '0; cmp_valid = 0; diag_mode = 0; clear = 0;
        m_fail = 0; m_mask = '0; m_first = '0; m_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (fail !== 1'b0 || fail_mask !== '0 || first_fail_idx !== '0) begin
            errors++;
            $display("FAIL R2 reset: actual fail=%b mask=%b idx=%0d expected 0 0 0", fail, fail_mask, first_fail_idx);
        end
        rst = 0;

        // R3 negative: equal responses never fail
        step(6'h01, mk(8'hA5, '0), 1, 0, 0, "R3 equal a");
        step(6'h2A, mk(8'h00, '0), 1, 0, 0, "R3 equal b");
        step(6'h3F, mk(8'hFF, '0), 1, 0, 0, "R3 equal c");
        // R4: mismatch without strobe ignored, both modes
        step(6'h05, mk(8'h11, 40'h01 << (3*W)), 0, 0, 0, "R4 idle xchk");
        step(6'h06, mk(8'h11, 40'h80 << (2*W)), 0, 1, 0, "R4 idle locate");
        // R3/R5/R7: single bit in router 1, first index 3
        step(6'h07, mk(8'h3C, 40'h01 << W), 1, 0, 0, "R3 R5 R7 first fail");
        // R9: holds over passing cycles
        step(6'h08, mk(8'h3C, '0), 1, 0, 0, "R9 hold a");
        step(6'h09, mk(8'h5A, '0), 1, 0, 0, "R9 hold b");
        step(6'h0A, mk(8'h5A, 40'hF0 << (4*W)), 1, 0, 0, "R7 index kept");
        // R8: clear beats a failing compare
        step(6'h0B, mk(8'h5A, 40'hFF), 1, 1, 1, "R8 clear priority");
        // R6 locate mode
        step(6'h0C, mk(8'h77, '0), 1, 1, 0, "R6 equal");
        step(6'h0D, mk(8'h77, 40'h20 << (2*W)), 1, 1, 0, "R6 router2");
        fl = (40'h01 << (4*W)) | 40'h80;
        step(6'h0E, mk(8'h77, fl), 1, 1, 0, "R6 routers 0 and 4 accumulate");
        fl = (40'h08 << W) | 40'h08;
        step(6'h0F, mk(8'h00, fl), 1, 1, 0, "R6 two-router minority");
        step(6'h10, mk(8'h00, 40'h04 << (3*W)), 1, 0, 0, "R5 mask kept in xchk");
        step(6'h11, mk(8'h00, '0), 0, 0, 1, "R8 clear");
        // mixed random tail
        for (int k = 0; k < 40; k++) begin
            logic [N*W-1:0] rf;
            rf = '0;
            if ($urandom_range(0, 2) == 0) rf[$urandom_range(0, N*W-1)] = 1'b1;
            step(6'($urandom), mk(8'($urandom), rf), 1'($urandom_range(0, 3) != 0),
                 1'($urandom), 1'($urandom_range(0, 9) == 0), "R3 R6 R7 mixed");
        end
        @(posedge clk);
        #6;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule